// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between the PWM waveform logic and the gate drivers of a half bridge. It takes two PWM inputs, channel A and channel B. It turns them into two gate-drive outputs, so that the high-side and low-side switches are never driven on at the same time. Two delay paths do the work. A rising-delay path postpones the rising edge of its source. A falling-delay path postpones the falling edge of its source. Each delay is programmed separately, in periods of the time-base clock.

A 6-bit control word sets up the routing, with three fields:

- `ctrl_i[5:4]` chooses which input feeds each delay path.
- `ctrl_i[1:0]` chooses which outputs take a delayed path and which take their own input undelayed.
- `ctrl_i[3:2]` chooses whether each delayed path is inverted.

These choices are independent per path. One word therefore covers the usual modes: pass-through, active-high and active-low complementary pairs, single-edge bypass, and mixed-source routings where each delay takes a different input.

All inputs are sampled on the time-base clock. The outputs are registered. A change on a PWM input first shows on an output two clock edges later, plus the programmed delay where one applies.

Top module: `deadband_gen`

## Requirements
- R1: While `rst_ni` is low at a clock edge, both outputs are 0 after that edge, whatever the polarity setting, and the edge counters restart from zero.
- R2: Input-mode field `ctrl_i[5:4]` routes the inputs to the delay paths:
  - 00: A feeds both paths.
  - 01: B feeds the rising path and A feeds the falling path.
  - 10: A feeds the rising path and B feeds the falling path.
  - 11: B feeds both paths.
  An input that feeds no path and is not bypassed has no effect on the outputs.
- R3: With output-mode field `ctrl_i[1:0]` = 00, `gate_a_o` equals `pwm_a_i` and `gate_b_o` equals `pwm_b_i`, each two clock edges late, with no inversion.
- R4: Output mode 01 gives `gate_a_o` = `pwm_a_i` undelayed and `gate_b_o` = the falling path. Output mode 10 gives `gate_a_o` = the rising path and `gate_b_o` = `pwm_b_i` undelayed. So bit 1 selects the rising path onto A, and bit 0 selects the falling path onto B.
- R5: Output mode 11 drives `gate_a_o` from the rising path and `gate_b_o` from the falling path.
- R6: `ctrl_i[2]` inverts the rising path and `ctrl_i[3]` inverts the falling path. Each inversion applies only where that path is selected onto an output. With output mode 11, the polarity codes give these pairs:
  - `ctrl_i[3:2]` = 10: active-high complementary.
  - 01: active-low complementary.
  - 00: both active high.
  - 11: both active low.
- R7: With rising delay D, a source that rises and stays high makes the rising path rise D clock periods later than it would with D = 0. A falling edge of the source passes with no added delay.
- R8: With falling delay D, a source that falls and stays low makes the falling path fall D clock periods later than it would with D = 0. A rising edge of the source passes with no added delay.
- R9: A source pulse that lasts D or fewer clock periods, against a delay D, produces no delayed edge. The delayed path does not toggle for that pulse.
- R10: A delay value of 0 adds no wait. The delayed path then tracks its source with the same latency as the bypass.
- R11: Both delay values cover the full 10-bit range. A delay of 1023 postpones the edge by exactly 1023 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-base clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pwm_a_i | input | 1 | PWM input, channel A |
| pwm_b_i | input | 1 | PWM input, channel B |
| ctrl_i | input | 6 | [5:4] input mode, [3:2] polarity, [1:0] output mode |
| rise_dly_i | input | 10 | Rising-edge delay in clock periods |
| fall_dly_i | input | 10 | Falling-edge delay in clock periods |
| gate_a_o | output | 1 | Gate-drive output A |
| gate_b_o | output | 1 | Gate-drive output B |

## Verification
Some rules hold on every cycle, and the assertions check those:
- Both outputs are low after a reset edge.
- Each bypassed output equals its input from two edges earlier.
- A delayed path never moves to its delayed level unless its source was already at that level.
- The opposite edge always passes straight through.

The exact length of each delay needs the bench's scenarios to show it. The same holds for the cancellation of short pulses and short gaps, the routing of each input-mode code, the pairing of polarity codes and the full 1023-period delay. Each scenario compares the timed waveforms against windows worked out from the requirements.

// File: rtl/dbg_pkg.sv
// Shared types for the dead-band generator.
// Assumes the 6-bit control word layout described in the brief.
package dbg_pkg;

    localparam int CTRL_W = 6;

    // Routing of the two inputs into the rising and falling delay paths.
    typedef enum logic [1:0] {
        SRC_A_BOTH      = 2'b00,
        SRC_B_RISE_ONLY = 2'b01,
        SRC_A_RISE_ONLY = 2'b10,
        SRC_B_BOTH      = 2'b11
    } src_sel_e;

    // Control word, MSB first: source select, falling inversion,
    // rising inversion, rising path onto A, falling path onto B.
    typedef struct packed {
        src_sel_e src_sel;
        logic     inv_fall;
        logic     inv_rise;
        logic     use_rise;
        logic     use_fall;
    } ctrl_t;

endpackage

// File: rtl/dbg_src_select.sv
// Source selector: picks the input that feeds each delay path.
// Purely combinational; assumes both inputs are already synchronous.
module dbg_src_select
    import dbg_pkg::*;
(
    input  logic     pwm_a_i,
    input  logic     pwm_b_i,
    input  src_sel_e src_sel_i,
    output logic     rise_src_o,
    output logic     fall_src_o
);

    // Decode the routing code into one source per path.
    always_comb begin
        unique case (src_sel_i)
            SRC_A_BOTH: begin
                rise_src_o = pwm_a_i;
                fall_src_o = pwm_a_i;
            end
            SRC_B_RISE_ONLY: begin
                rise_src_o = pwm_b_i;
                fall_src_o = pwm_a_i;
            end
            SRC_A_RISE_ONLY: begin
                rise_src_o = pwm_a_i;
                fall_src_o = pwm_b_i;
            end
            default: begin
                rise_src_o = pwm_b_i;
                fall_src_o = pwm_b_i;
            end
        endcase
    end

endmodule

// File: rtl/dbg_edge_delay.sv
// Single-edge delay path. The edge INTO DELAYED_LEVEL is postponed
// until the source has held that level for dly_i + 1 samples. The edge
// away from it passes on the next clock. Shorter excursions are dropped.
// Assumes src_i is synchronous to clk_i. Reset output level is 0.
module dbg_edge_delay #(
    parameter int DLY_W         = 10,
    parameter bit DELAYED_LEVEL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             src_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             dly_o
);

    logic [DLY_W-1:0] run_q;
    logic             lvl_q;

    // Count how long the source has sat at the delayed level; release the edge at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else if (src_i != DELAYED_LEVEL) begin
            run_q <= '0;
            lvl_q <= src_i;
        end else if (run_q >= dly_i) begin
            lvl_q <= DELAYED_LEVEL;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign dly_o = lvl_q;

    AST_NO_EARLY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q == DELAYED_LEVEL && $past(lvl_q) != DELAYED_LEVEL)
            |-> $past(src_i) == DELAYED_LEVEL); // R9

    AST_FAST_EDGE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(src_i) != DELAYED_LEVEL)
            |-> lvl_q == $past(src_i)); // R7

endmodule

// File: rtl/dbg_out_stage.sv
// Output stage: per output, choose the delayed path (optionally
// inverted) or the undelayed input, and register the result.
// Assumes all inputs come from registers in the same clock domain.
module dbg_out_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic byp_a_i,
    input  logic byp_b_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic use_rise_i,
    input  logic use_fall_i,
    input  logic inv_rise_i,
    input  logic inv_fall_i,
    output logic gate_a_o,
    output logic gate_b_o
);

    logic nxt_a;
    logic nxt_b;

    // Select and polarise the next value of each output.
    always_comb begin
        nxt_a = use_rise_i ? (rise_i ^ inv_rise_i) : byp_a_i;
        nxt_b = use_fall_i ? (fall_i ^ inv_fall_i) : byp_b_i;
    end

    // Register both outputs; reset forces the inactive, un-inverted level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_a_o <= 1'b0;
            gate_b_o <= 1'b0;
        end else begin
            gate_a_o <= nxt_a;
            gate_b_o <= nxt_b;
        end
    end

endmodule

// File: rtl/deadband_gen.sv
// Dead-band generator top. Samples the two PWM inputs, routes them to a
// rising-delay and a falling-delay path, then selects and polarises the
// outputs. Latency from input to output is two edges plus any delay.
// Assumes the PWM inputs and the control word are synchronous to clk_i.
module deadband_gen
    import dbg_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwm_a_i,
    input  logic              pwm_b_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [DLY_W-1:0]  rise_dly_i,
    input  logic [DLY_W-1:0]  fall_dly_i,
    output logic              gate_a_o,
    output logic              gate_b_o
);

    localparam int NPATH = 2;

    ctrl_t            ctrl;
    logic             byp_a_q;
    logic             byp_b_q;
    logic [NPATH-1:0] path_src;
    logic [NPATH-1:0] path_out;
    logic [DLY_W-1:0] path_dly [NPATH];

    assign ctrl = ctrl_t'(ctrl_i);

    // Capture the inputs so the bypass route matches the delay-path latency.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            byp_a_q <= 1'b0;
            byp_b_q <= 1'b0;
        end else begin
            byp_a_q <= pwm_a_i;
            byp_b_q <= pwm_b_i;
        end
    end

    dbg_src_select u_src (
        .pwm_a_i    (pwm_a_i),
        .pwm_b_i    (pwm_b_i),
        .src_sel_i  (ctrl.src_sel),
        .rise_src_o (path_src[0]),
        .fall_src_o (path_src[1])
    );

    assign path_dly[0] = rise_dly_i;
    assign path_dly[1] = fall_dly_i;

    // Path 0 delays rising edges, path 1 delays falling edges.
    for (genvar p = 0; p < NPATH; p++) begin : g_path
        dbg_edge_delay #(
            .DLY_W         (DLY_W),
            .DELAYED_LEVEL (p == 0)
        ) u_delay (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .src_i  (path_src[p]),
            .dly_i  (path_dly[p]),
            .dly_o  (path_out[p])
        );
    end

    dbg_out_stage u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .byp_a_i    (byp_a_q),
        .byp_b_i    (byp_b_q),
        .rise_i     (path_out[0]),
        .fall_i     (path_out[1]),
        .use_rise_i (ctrl.use_rise),
        .use_fall_i (ctrl.use_fall),
        .inv_rise_i (ctrl.inv_rise),
        .inv_fall_i (ctrl.inv_fall),
        .gate_a_o   (gate_a_o),
        .gate_b_o   (gate_b_o)
    );

    AST_RESET_CLEARS_OUT: assert property (@(posedge clk_i)
        !rst_ni |=> (gate_a_o == 1'b0 && gate_b_o == 1'b0)); // R1

    AST_BYPASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2) && !$past(ctrl_i[1]))
            |-> gate_a_o == $past(pwm_a_i, 2)); // R3

    AST_BYPASS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2) && !$past(ctrl_i[0]))
            |-> gate_b_o == $past(pwm_b_i, 2)); // R4

endmodule

// File: tb/deadband_gen_tb.sv
`timescale 1ns/1ps
module deadband_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_a = 1'b0;
    logic       pwm_b = 1'b0;
    logic [5:0] ctrl = '0;
    logic [9:0] rdly = '0;
    logic [9:0] fdly = '0;
    logic       gate_a;
    logic       gate_b;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    deadband_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pwm_a_i    (pwm_a),
        .pwm_b_i    (pwm_b),
        .ctrl_i     (ctrl),
        .rise_dly_i (rdly),
        .fall_dly_i (fdly),
        .gate_a_o   (gate_a),
        .gate_b_o   (gate_b)
    );

    // Pulse on each input over samples [start, start+len). The expected
    // output is high over observed iterations [s, e), then XOR inv.
    typedef struct packed {
        logic [5:0] ctrl;
        logic [9:0] rdly;
        logic [9:0] fdly;
        logic [7:0] a_st;
        logic [7:0] a_len;
        logic [7:0] b_st;
        logic [7:0] b_len;
        logic [7:0] ea_s;
        logic [7:0] ea_e;
        logic       ea_inv;
        logic [7:0] eb_s;
        logic [7:0] eb_e;
        logic       eb_inv;
        logic [3:0] req;
    } vec_t;

    localparam int NV  = 14;
    localparam int WIN = 48;
    localparam vec_t VT [NV] = '{
        '{6'h0C, 10'd3, 10'd5, 8'd4, 8'd10, 8'd20, 8'd6, 8'd6,  8'd16, 1'b0, 8'd22, 8'd28, 1'b0, 4'd3},  // R3, R6 bypass ignores polarity
        '{6'h03, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd9,  8'd16, 1'b0, 8'd6,  8'd21, 1'b0, 4'd5},  // R5 active high, R2 B unused
        '{6'h0B, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd9,  8'd16, 1'b0, 8'd6,  8'd21, 1'b1, 4'd6},  // R6 active-high complementary
        '{6'h07, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd9,  8'd16, 1'b1, 8'd6,  8'd21, 1'b0, 4'd6},  // R6 active-low complementary
        '{6'h0F, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd9,  8'd16, 1'b1, 8'd6,  8'd21, 1'b1, 4'd6},  // R6 active low
        '{6'h01, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd6,  8'd16, 1'b0, 8'd6,  8'd21, 1'b0, 4'd4},  // R4 mode 01
        '{6'h02, 10'd3, 10'd5, 8'd4, 8'd10, 8'd30, 8'd3, 8'd9,  8'd16, 1'b0, 8'd32, 8'd35, 1'b0, 4'd4},  // R4 mode 10
        '{6'h13, 10'd2, 10'd4, 8'd4, 8'd6,  8'd20, 8'd10, 8'd24, 8'd32, 1'b0, 8'd6, 8'd16, 1'b0, 4'd2},  // R2 code 01
        '{6'h23, 10'd2, 10'd4, 8'd4, 8'd6,  8'd20, 8'd10, 8'd8,  8'd12, 1'b0, 8'd22, 8'd36, 1'b0, 4'd2}, // R2 code 10
        '{6'h33, 10'd1, 10'd0, 8'd4, 8'd4,  8'd20, 8'd10, 8'd23, 8'd32, 1'b0, 8'd22, 8'd32, 1'b0, 4'd2}, // R2 code 11
        '{6'h03, 10'd0, 10'd0, 8'd4, 8'd5,  8'd0,  8'd0, 8'd6,  8'd11, 1'b0, 8'd6,  8'd11, 1'b0, 4'd10}, // R10 zero delay
        '{6'h03, 10'd6, 10'd2, 8'd4, 8'd5,  8'd0,  8'd0, 8'd0,  8'd0,  1'b0, 8'd6,  8'd13, 1'b0, 4'd9},  // R9 short pulse dropped
        '{6'h03, 10'd4, 10'd0, 8'd4, 8'd5,  8'd0,  8'd0, 8'd10, 8'd11, 1'b0, 8'd6,  8'd11, 1'b0, 4'd7},  // R7 pulse of D+1
        '{6'h03, 10'd4, 10'd3, 8'd4, 8'd4,  8'd0,  8'd0, 8'd0,  8'd0,  1'b0, 8'd6,  8'd13, 1'b0, 4'd8}   // R8 fall delay, R9 pulse of D
    };

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Reset with the given setup, leaving the bench at a falling edge with reset released.
    task automatic start(input logic [5:0] c, input logic [9:0] r, input logic [9:0] f);
        @(negedge clk);
        rst_n = 1'b0;
        pwm_a = 1'b0;
        pwm_b = 1'b0;
        ctrl  = c;
        rdly  = r;
        fdly  = f;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int  bad_a = -1;
        int  bad_b = -1;
        logic ga = 1'b0, gb = 1'b0, xa = 1'b0, xb = 1'b0;
        start(v.ctrl, v.rdly, v.fdly);
        for (int n = 0; n < WIN; n++) begin
            pwm_a = (n >= v.a_st) && (n < v.a_st + v.a_len);
            pwm_b = (n >= v.b_st) && (n < v.b_st + v.b_len);
            if (n >= 2) begin
                logic ea, eb;
                ea = ((n >= v.ea_s) && (n < v.ea_e)) ^ v.ea_inv;
                eb = ((n >= v.eb_s) && (n < v.eb_e)) ^ v.eb_inv;
                if (gate_a !== ea && bad_a < 0) begin bad_a = n; ga = gate_a; xa = ea; end
                if (gate_b !== eb && bad_b < 0) begin bad_b = n; gb = gate_b; xb = eb; end
            end
            @(negedge clk);
        end
        n_run += 2;
        if (bad_a >= 0) begin
            n_fail++;
            $display("FAIL R%0d vector %0d gate_a at step %0d: got %0b expected %0b", v.req, idx, bad_a, ga, xa);
        end
        if (bad_b >= 0) begin
            n_fail++;
            $display("FAIL R%0d vector %0d gate_b at step %0d: got %0b expected %0b", v.req, idx, bad_b, gb, xb);
        end
    endtask

    initial begin
        // R1: outputs low during reset even with both paths inverted.
        ctrl = 6'h0F;
        pwm_a = 1'b1;
        pwm_b = 1'b1;
        repeat (3) @(negedge clk);
        check(gate_a, 1'b0, "R1", "gate_a in reset");
        check(gate_b, 1'b0, "R1", "gate_b in reset");

        for (int i = 0; i < NV; i++) run_vec(VT[i], i);

        // R1: reset in mid-run clears high outputs after one edge.
        start(6'h00, 10'd0, 10'd0);
        pwm_a = 1'b1;
        pwm_b = 1'b1;
        repeat (4) @(negedge clk);
        check(gate_a, 1'b1, "R3", "gate_a passes high");
        rst_n = 1'b0;
        @(negedge clk);
        check(gate_a, 1'b0, "R1", "gate_a after reset edge");
        check(gate_b, 1'b0, "R1", "gate_b after reset edge");

        // R8, R9: a low gap shorter than the falling delay is swallowed.
        start(6'h03, 10'd0, 10'd5);
        begin
            int bad = 0;
            for (int n = 0; n < 40; n++) begin
                pwm_a = ((n >= 4) && (n < 10)) || ((n >= 13) && (n < 20));
                if (n >= 2) begin
                    logic eb, ea;
                    eb = (n >= 6) && (n < 27);
                    ea = ((n >= 6) && (n < 12)) || ((n >= 15) && (n < 22));
                    if (gate_b !== eb || gate_a !== ea) bad++;
                end
                @(negedge clk);
            end
            check(bad == 0, 1'b1, "R9", "short low gap on falling path");
        end

        // R11: full-range rising delay, R8: the rising edge on B is immediate.
        start(6'h03, 10'd1023, 10'd0);
        for (int n = 0; n < 1032; n++) begin
            pwm_a = (n >= 4);
            if (n == 6)    check(gate_b, 1'b1, "R8", "falling path rises at once");
            if (n == 1028) check(gate_a, 1'b0, "R11", "gate_a before 1023 periods");
            if (n == 1029) check(gate_a, 1'b1, "R11", "gate_a after 1023 periods");
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule